// File: doc/BRIEF.md
# Boot-Time Fuse Configuration Loader

After reset, this block reads a small one-time-programmable configuration region once. It uses a simple synchronous read port whose data comes back one clock after the request. It checks the region's integrity in two independent ways. Only when both checks pass does it release a set of processor-level control bits: debug disable, boot source, clock source, watchdog timeout code and a programming-lock output. Firmware has no write path into the block, so the latched values cannot be overridden once loaded.

Until loading finishes, and permanently if a check fails, every output holds a safe default. The safe defaults are: debug disabled, boot source 0, clock source 0, the longest watchdog code, and further fuse programming inhibited.

Corruption is reported through two sticky flags that tell a complement mismatch apart from a CRC mismatch. Completion is signalled by a single-cycle done strobe.

Top module: `fuse_cfg_loader`

## Requirements
- R1: After reset is released, the block reads addresses 0 to LEN-1 (LEN = 2*N_CFG+3) exactly once each. The reads are in ascending order on consecutive cycles. The block takes the data one cycle after each request and issues no read after that.
- R2: From reset until the done strobe, the outputs hold safe defaults: dbg_disable=1, boot_src=0, clk_src=0, wdt_code=4'hF, prog_lock=1.
- R3: Configuration byte i is stored at address 2i, and its bitwise complement at address 2i+1. If any pair disagrees, err_cmp is set and every configuration output keeps its safe default.
- R4: A CRC-16 is computed over addresses 0 to 2N_CFG-1. It uses polynomial 0x1021, start value 0xFFFF, MSB first, and no final inversion. The stored value sits with its high byte at address 2N_CFG and its low byte at 2N_CFG+1. On a mismatch, err_crc is set and every output keeps its safe default.
- R5: On a clean load, the fields decode as follows. dbg_disable is the inverse of bit 0 of byte 0. boot_src is byte 0 bits [2:1]. clk_src is byte 0 bit 3. wdt_code is byte 1 bits [3:0]. An erased byte reads 0xFF, and a programmed bit reads 0.
- R6: The lock byte is at address LEN-1 and is outside the CRC. On a clean load, prog_lock is 1 when its bit 0 is programmed (0) and 0 when that bit is erased (1). After any error, prog_lock stays 1.
- R7: load_done is high for exactly one cycle per reset, after the lock byte has been returned.
- R8: After load_done, all outputs and both error flags stay constant until the next reset.
- R9: A complement mismatch and a CRC mismatch in the same image are both flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| otp_addr | output | AW | Read address to the fuse region |
| otp_rd_en | output | 1 | Read request; data is returned the next cycle |
| otp_rd_data | input | 8 | Byte returned by the region |
| dbg_disable | output | 1 | 1 = debug access blocked |
| boot_src | output | 2 | Boot source select |
| clk_src | output | 1 | Clock source select |
| wdt_code | output | 4 | Watchdog timeout code (4'hF longest) |
| prog_lock | output | 1 | 1 = later fuse programming inhibited |
| load_done | output | 1 | One-cycle strobe when loading completes |
| err_cmp | output | 1 | Sticky: a value/complement pair disagreed |
| err_crc | output | 1 | Sticky: recomputed CRC differs from stored CRC |

## Verification
The bench loads a fully erased image, a programmed image with the lock set, and images damaged in a complement byte, in a stored CRC byte, and in both. A loader that released values before checking would show non-default outputs during the load or after a failed check. A loader that folded the lock byte into the CRC, or mixed up the CRC byte order, would report false CRC errors on good images. The bench also watches the read addresses, the width of the done strobe, and output stability long after loading. This exposes a loader that skips or repeats an address, strobes twice, or keeps reading after completion.

// File: rtl/fuse_cfg_pkg.sv
// Package: shared types, safe defaults and the CRC step for the fuse loader.
// Assumes an 8-bit read port and MSB-first CRC-16 with polynomial 0x1021.
package fuse_cfg_pkg;

    typedef struct packed {
        logic       dbg_disable;
        logic [1:0] boot_src;
        logic       clk_src;
        logic [3:0] wdt_code;
        logic       prog_lock;
    } fuse_cfg_t;

    localparam fuse_cfg_t CFG_SAFE = '{
        dbg_disable: 1'b1,
        boot_src:    2'd0,
        clk_src:     1'b0,
        wdt_code:    4'hF,
        prog_lock:   1'b1
    };

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_DONE
    } seq_state_t;

    // Advance a CRC by one byte, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        c = crc_in;
        for (int b = 7; b >= 0; b--) begin
            if (c[15] ^ data[b]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else                 c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/fuse_rd_seq.sv
// Read sequencer: after reset, steps the fuse address from 0 to LEN-1,
// one request per cycle, then stops for good. It delays the request
// by one cycle so that consumers see valid data with its index.
// Assumes the region returns data exactly one cycle after a request.
module fuse_rd_seq
    import fuse_cfg_pkg::*;
#(
    parameter int AW  = 8,
    parameter int LEN = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] rd_addr,
    output logic          rd_en,
    output logic          rvalid,
    output logic [AW-1:0] ridx
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(LEN - 1);

    seq_state_t    state_q;
    logic [AW-1:0] addr_q;

    assign rd_en   = (state_q == SEQ_READ);
    assign rd_addr = addr_q;

    // Walk the address range once, then park in the finished state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: state_q <= SEQ_READ;
                SEQ_READ: begin
                    if (addr_q == LAST_ADDR) state_q <= SEQ_DONE;
                    else                     addr_q  <= addr_q + 1'b1;
                end
                default:  state_q <= SEQ_DONE;
            endcase
        end
    end

    // Pair each returned byte with the address it was requested from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            ridx   <= '0;
        end else begin
            rvalid <= rd_en;
            ridx   <= addr_q;
        end
    end

endmodule

// File: rtl/fuse_crc16.sv
// Running CRC-16 over the protected bytes, those with index below
// PROT_LEN. Assumes bytes arrive in address order, at most one per cycle.
module fuse_crc16
    import fuse_cfg_pkg::*;
#(
    parameter int AW       = 8,
    parameter int PROT_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rvalid,
    input  logic [AW-1:0] ridx,
    input  logic [7:0]    rdata,
    output logic [15:0]   crc
);
    localparam logic [AW-1:0] PROT_END = AW'(PROT_LEN);

    // Fold every protected byte into the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)                          crc <= CRC_INIT;
        else if (rvalid && ridx < PROT_END)  crc <= crc16_step(crc, rdata);
    end

endmodule

// File: rtl/fuse_cfg_latch.sv
// Checker and latch: captures each value byte, compares it with its
// complement, captures the stored CRC, and on the lock byte commits
// either the decoded configuration or the safe defaults, with a done
// strobe. Assumes bytes arrive in address order with their index.
module fuse_cfg_latch
    import fuse_cfg_pkg::*;
#(
    parameter int AW    = 8,
    parameter int N_CFG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rvalid,
    input  logic [AW-1:0] ridx,
    input  logic [7:0]    rdata,
    input  logic [15:0]   crc_calc,
    output fuse_cfg_t     cfg,
    output logic          load_done,
    output logic          err_cmp,
    output logic          err_crc
);
    localparam int            LEN        = 2 * N_CFG + 3;
    localparam logic [AW-1:0] IDX_CRC_HI = AW'(2 * N_CFG);
    localparam logic [AW-1:0] IDX_CRC_LO = AW'(2 * N_CFG + 1);
    localparam logic [AW-1:0] IDX_LOCK   = AW'(LEN - 1);

    logic [N_CFG-1:0][7:0] pair_val;
    logic [N_CFG-1:0]      pair_bad;
    logic [7:0]            crc_hi_q, crc_lo_q;
    logic                  commit, load_ok, crc_ok;
    fuse_cfg_t             decoded;

    for (genvar i = 0; i < N_CFG; i++) begin : g_pair
        localparam logic [AW-1:0] IDX_VAL = AW'(2 * i);
        localparam logic [AW-1:0] IDX_INV = AW'(2 * i + 1);
        logic [7:0] val_q;
        logic       bad_q;

        // Keep the value byte and flag it if its complement disagrees.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= 8'h00;
                bad_q <= 1'b0;
            end else if (rvalid) begin
                if (ridx == IDX_VAL) val_q <= rdata;
                if (ridx == IDX_INV && rdata != ~val_q) bad_q <= 1'b1;
            end
        end

        assign pair_val[i] = val_q;
        assign pair_bad[i] = bad_q;
    end

    // Capture the stored CRC, high byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_hi_q <= 8'h00;
            crc_lo_q <= 8'h00;
        end else if (rvalid) begin
            if (ridx == IDX_CRC_HI) crc_hi_q <= rdata;
            if (ridx == IDX_CRC_LO) crc_lo_q <= rdata;
        end
    end

    assign commit  = rvalid && (ridx == IDX_LOCK);
    assign crc_ok  = ({crc_hi_q, crc_lo_q} == crc_calc);
    assign load_ok = crc_ok && !(|pair_bad);

    // Map the checked bytes onto the control fields (programmed bit = 0).
    always_comb begin
        decoded.dbg_disable = ~pair_val[0][0];
        decoded.boot_src    = pair_val[0][2:1];
        decoded.clk_src     = pair_val[0][3];
        decoded.wdt_code    = pair_val[1][3:0];
        decoded.prog_lock   = ~rdata[0];
    end

    // Commit once on the lock byte; safe defaults hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg       <= CFG_SAFE;
            load_done <= 1'b0;
            err_cmp   <= 1'b0;
            err_crc   <= 1'b0;
        end else begin
            load_done <= commit;
            if (commit) begin
                err_cmp <= |pair_bad;
                err_crc <= !crc_ok;
                cfg     <= load_ok ? decoded : CFG_SAFE;
            end
        end
    end

endmodule

// File: rtl/fuse_cfg_loader.sv
// Top level: boot-time fuse configuration loader. Reads the region once
// after reset, checks complement pairs and CRC, then drives static
// control outputs. Assumes N_CFG >= 2 and one-cycle read latency.
// It has no write path, so software cannot alter the result.
module fuse_cfg_loader
    import fuse_cfg_pkg::*;
#(
    parameter int AW    = 8,
    parameter int N_CFG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] otp_addr,
    output logic          otp_rd_en,
    input  logic [7:0]    otp_rd_data,
    output logic          dbg_disable,
    output logic [1:0]    boot_src,
    output logic          clk_src,
    output logic [3:0]    wdt_code,
    output logic          prog_lock,
    output logic          load_done,
    output logic          err_cmp,
    output logic          err_crc
);
    localparam int LEN      = 2 * N_CFG + 3;
    localparam int PROT_LEN = 2 * N_CFG;

    logic          rvalid;
    logic [AW-1:0] ridx;
    logic [15:0]   crc_calc;
    fuse_cfg_t     cfg;

    fuse_rd_seq #(.AW(AW), .LEN(LEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (otp_addr),
        .rd_en   (otp_rd_en),
        .rvalid  (rvalid),
        .ridx    (ridx)
    );

    fuse_crc16 #(.AW(AW), .PROT_LEN(PROT_LEN)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .rvalid (rvalid),
        .ridx   (ridx),
        .rdata  (otp_rd_data),
        .crc    (crc_calc)
    );

    fuse_cfg_latch #(.AW(AW), .N_CFG(N_CFG)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rvalid    (rvalid),
        .ridx      (ridx),
        .rdata     (otp_rd_data),
        .crc_calc  (crc_calc),
        .cfg       (cfg),
        .load_done (load_done),
        .err_cmp   (err_cmp),
        .err_crc   (err_crc)
    );

    assign dbg_disable = cfg.dbg_disable;
    assign boot_src    = cfg.boot_src;
    assign clk_src     = cfg.clk_src;
    assign wdt_code    = cfg.wdt_code;
    assign prog_lock   = cfg.prog_lock;

endmodule

// File: rtl/fuse_cfg_loader_chk.sv
// Checker: temporal properties of the loader at its ports, bound to the top.
module fuse_cfg_loader_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] otp_addr,
    input logic          otp_rd_en,
    input logic          dbg_disable,
    input logic [1:0]    boot_src,
    input logic          clk_src,
    input logic [3:0]    wdt_code,
    input logic          prog_lock,
    input logic          load_done,
    input logic          err_cmp,
    input logic          err_crc
);
    logic done_seen;

    // Remember that the done strobe has been observed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_seen <= 1'b0;
        else if (load_done) done_seen <= 1'b1;
    end

    a_r2_safe_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_seen && !load_done) |->
            (dbg_disable && boot_src == 2'd0 && !clk_src && wdt_code == 4'hF && prog_lock));

    a_r1_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_rd_en && $past(otp_rd_en)) |-> (otp_addr == $past(otp_addr) + 1'b1));

    a_r1_no_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> !otp_rd_en);

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done);

    a_r7_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |-> !load_done);

    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_seen |=> $stable({dbg_disable, boot_src, clk_src, wdt_code, prog_lock, err_cmp, err_crc}));

    a_r3_error_keeps_safe: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done && (err_cmp || err_crc)) |->
            (dbg_disable && boot_src == 2'd0 && !clk_src && wdt_code == 4'hF && prog_lock));

endmodule

bind fuse_cfg_loader fuse_cfg_loader_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .otp_addr    (otp_addr),
    .otp_rd_en   (otp_rd_en),
    .dbg_disable (dbg_disable),
    .boot_src    (boot_src),
    .clk_src     (clk_src),
    .wdt_code    (wdt_code),
    .prog_lock   (prog_lock),
    .load_done   (load_done),
    .err_cmp     (err_cmp),
    .err_crc     (err_crc)
);

// File: tb/sim_fuse_cfg_loader.sv
// Directed bench: one task per scenario, fuse region modelled as a byte memory.
module sim_fuse_cfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int N_CFG      = 2;
    localparam int LEN        = 2 * N_CFG + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] otp_addr;
    logic          otp_rd_en;
    logic [7:0]    otp_rd_data;
    logic          dbg_disable, clk_src, prog_lock, load_done, err_cmp, err_crc;
    logic [1:0]    boot_src;
    logic [3:0]    wdt_code;

    logic [7:0] mem [LEN];
    int n_checks = 0, n_fail = 0;
    int rd_cnt = 0, done_cnt = 0, rd_expect = 0;
    bit seq_err = 0, early_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fuse_cfg_loader #(.AW(AW), .N_CFG(N_CFG)) u0 (
        .clk(clk), .rst_n(rst_n), .otp_addr(otp_addr), .otp_rd_en(otp_rd_en),
        .otp_rd_data(otp_rd_data), .dbg_disable(dbg_disable), .boot_src(boot_src),
        .clk_src(clk_src), .wdt_code(wdt_code), .prog_lock(prog_lock),
        .load_done(load_done), .err_cmp(err_cmp), .err_crc(err_crc)
    );

    // Region model: one-cycle read latency.
    always @(posedge clk) if (otp_rd_en) otp_rd_data <= mem[otp_addr];

    // Port monitor: read order, read count, done strobes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (otp_rd_en) begin
                if (int'(otp_addr) != rd_expect) seq_err = 1;
                rd_expect++;
                rd_cnt++;
            end
            if (load_done) done_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] b0, input logic [7:0] b1);
        logic [7:0] bytes [4];
        logic [15:0] r;
        bytes[0] = b0; bytes[1] = ~b0; bytes[2] = b1; bytes[3] = ~b1;
        r = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            r = r ^ {bytes[k], 8'h00};
            for (int j = 0; j < 8; j++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    task automatic build(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] lock);
        logic [15:0] c;
        c = ref_crc(b0, b1);
        mem[0] = b0; mem[1] = ~b0; mem[2] = b1; mem[3] = ~b1;
        mem[4] = c[15:8]; mem[5] = c[7:0]; mem[6] = lock;
    endtask

    function automatic bit outs_safe();
        return dbg_disable && boot_src == 2'd0 && !clk_src && wdt_code == 4'hF && prog_lock;
    endfunction

    // Reset, run one full load, and check reads, defaults and strobe (R1, R2, R7).
    task automatic run_load(input string tag);
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(outs_safe() && !load_done && !err_cmp && !err_crc, {tag, " R2 reset defaults"},
              {dbg_disable, boot_src, clk_src, wdt_code, prog_lock}, 9'h11F);
        rd_cnt = 0; done_cnt = 0; rd_expect = 0; seq_err = 0; early_bad = 0;
        rst_n = 1;
        for (int t = 0; t < 60 && done_cnt == 0; t++) begin
            @(negedge clk);
            if (done_cnt == 0 && !load_done && !outs_safe()) early_bad = 1;
        end
        check(!early_bad, {tag, " R2 defaults before done"}, early_bad, 0);
        repeat (30) @(negedge clk);
        check(rd_cnt == LEN && !seq_err, {tag, " R1 read sequence"}, rd_cnt, LEN);
        check(done_cnt == 1, {tag, " R7 single done strobe"}, done_cnt, 1);
    endtask

    task automatic expect_cfg(input string tag, input logic d, input logic [1:0] b,
                              input logic c, input logic [3:0] w, input logic l,
                              input logic ec, input logic ek);
        check(dbg_disable == d && boot_src == b && clk_src == c && wdt_code == w,
              {tag, " R5 fields"}, {dbg_disable, boot_src, clk_src, wdt_code}, {d, b, c, w});
        check(prog_lock == l, {tag, " R6 lock"}, prog_lock, l);
        check(err_cmp == ec, {tag, " R3 err_cmp"}, err_cmp, ec);
        check(err_crc == ek, {tag, " R4 err_crc"}, err_crc, ek);
    endtask

    task automatic t_erased();
        build(8'hFF, 8'hFF, 8'hFF);
        run_load("erased");
        expect_cfg("erased", 1'b0, 2'd3, 1'b1, 4'hF, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_programmed();
        build(8'h0A, 8'h03, 8'hFE);
        run_load("programmed");
        expect_cfg("programmed", 1'b1, 2'd1, 1'b1, 4'h3, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_cmp_bad();
        logic [15:0] c;
        build(8'h0A, 8'h03, 8'hFF);
        mem[3] = 8'hFD;
        c = 16'hFFFF;
        for (int k = 0; k < 4; k++) begin
            c = c ^ {mem[k], 8'h00};
            for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        mem[4] = c[15:8]; mem[5] = c[7:0];
        run_load("cmp_bad");
        expect_cfg("cmp_bad R3", 1'b1, 2'd0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_crc_bad();
        build(8'h0A, 8'h03, 8'hFF);
        mem[5] = mem[5] ^ 8'h01;
        run_load("crc_bad");
        expect_cfg("crc_bad R4", 1'b1, 2'd0, 1'b0, 4'hF, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_both_bad();
        build(8'h0A, 8'h03, 8'hFE);
        mem[1] = 8'h00;
        mem[4] = mem[4] ^ 8'h80;
        run_load("both_bad");
        expect_cfg("both_bad R9", 1'b1, 2'd0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b1);
    endtask

    // Change the region after loading; outputs must not follow (R8).
    task automatic t_hold();
        logic [8:0] snap;
        build(8'h0A, 8'h03, 8'hFE);
        run_load("hold");
        snap = {dbg_disable, boot_src, clk_src, wdt_code, prog_lock};
        build(8'hFF, 8'hFF, 8'hFF);
        repeat (100) @(negedge clk);
        check({dbg_disable, boot_src, clk_src, wdt_code, prog_lock} == snap && !err_cmp && !err_crc,
              "hold R8 outputs stable", {dbg_disable, boot_src, clk_src, wdt_code, prog_lock}, snap);
        check(rd_cnt == LEN && done_cnt == 1, "hold R1 R7 no further activity", rd_cnt, LEN);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_erased();
        t_programmed();
        t_cmp_bad();
        t_crc_bad();
        t_both_bad();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule